// File: doc/BRIEF.md
# Processor Status Flag Register

This block is the 8-bit status register of a small microcontroller core. It holds four arithmetic flags (carry, half carry, zero, overflow) produced by the ALU, and two system flags: power-down and watchdog time-out. The core reads and writes it at one address on its data bus. The ALU updates the arithmetic flags through a per-flag update mask.

The two system flags are protected from software. They move only on event pulses: power-up, the watchdog-clear instruction, the halt instruction and a watchdog time-out. A bus write can change the arithmetic flags but leaves the system flags alone. The register is not saved or restored by the block on interrupt entry or subroutine call; the program does that if it needs to.

Top module: `status_reg`

## Requirements
- R1: Bit layout of `status_o`: bit 0 carry, bit 1 half carry, bit 2 zero, bit 3 overflow, bit 4 power-down, bit 5 time-out. Bits 6 and 7 always read 0.
- R2: A bus write (`bus_we_i`=1) with `bus_addr_i` equal to `REG_ADDR` (default 0x0A) loads bits 3:0 from `bus_wdata_i[3:0]` at the next clock edge. A write to any other address changes nothing.
- R3: A bus write never changes the power-down or time-out bit, whatever the value of `bus_wdata_i[5:4]`.
- R4: Power-down is cleared by `wdt_clr_i` and set by `halt_i`. If both arrive in the same cycle, power-down ends cleared.
- R5: Time-out is set by `wdt_to_i` and cleared by `wdt_clr_i` or `halt_i`. If a time-out arrives together with a clear or a halt, time-out ends set.
- R6: A `pwr_up_i` pulse clears power-down and time-out, overriding every other event in the same cycle. It leaves bits 3:0 unchanged.
- R7: For each bit i of `alu_upd_i` that is 1, flag i takes `alu_flags_i[i]` (0 C, 1 AC, 2 Z, 3 OV). Within a cycle this takes priority over a bus write to the same flag. Flags whose mask bit is 0 take the bus write, if there is one, or else hold.
- R8: Asynchronous reset (`rst_ni`=0) clears all eight bits.
- R9: `bus_rdata_o` shows the assembled byte when `bus_addr_i` equals `REG_ADDR`. At any other address it shows 0. The read path is combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | ADDR_W | Data bus address |
| bus_we_i | input | 1 | Bus write strobe |
| bus_wdata_i | input | 8 | Bus write data |
| bus_rdata_o | output | 8 | Bus read data |
| alu_upd_i | input | 4 | Per-flag ALU update mask |
| alu_flags_i | input | 4 | ALU flag values |
| pwr_up_i | input | 1 | Power-up event pulse |
| wdt_clr_i | input | 1 | Watchdog-clear instruction pulse |
| halt_i | input | 1 | Halt instruction pulse |
| wdt_to_i | input | 1 | Watchdog time-out pulse |
| status_o | output | 8 | Current register value |

## Verification
The assertions assume the event inputs are single-cycle pulses, sampled synchronously, and free of X after reset. They are written so that they still hold when several events coincide. They also assume the ALU mask and the bus write may fall in the same cycle. The bench drives every input on the falling edge and releases each event pulse after one cycle. It walks through every combination of the four events, and it sends random bus writes with all data patterns, including writes to other addresses.

// File: rtl/status_pkg.sv
package status_pkg;
  localparam int unsigned NUM_ALU_FLAGS = 4;
  localparam int unsigned REG_W         = 8;
  localparam int unsigned PD_BIT        = 4;
  localparam int unsigned TO_BIT        = 5;

  typedef struct packed {
    logic to;
    logic pd;
  } sys_flags_t;
endpackage

// File: rtl/status_alu_flags.sv
module status_alu_flags
  import status_pkg::*;
(
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_hit_i,
  input  logic [NUM_ALU_FLAGS-1:0] wr_data_i,
  input  logic [NUM_ALU_FLAGS-1:0] alu_upd_i,
  input  logic [NUM_ALU_FLAGS-1:0] alu_flags_i,
  output logic [NUM_ALU_FLAGS-1:0] flags_o
);
  for (genvar i = 0; i < NUM_ALU_FLAGS; i++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)           flags_o[i] <= 1'b0;
      else if (alu_upd_i[i]) flags_o[i] <= alu_flags_i[i];
      else if (wr_hit_i)     flags_o[i] <= wr_data_i[i];
    end

    // R7: ALU value lands regardless of a concurrent write
    a_r7_alu_wins : assert property (@(posedge clk_i) disable iff (!rst_ni)
      alu_upd_i[i] |=> flags_o[i] == $past(alu_flags_i[i]));
    // R2: idle flags hold
    a_r2_hold : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!alu_upd_i[i] && !wr_hit_i) |=> $stable(flags_o[i]));
  end
endmodule

// File: rtl/status_sys_flags.sv
module status_sys_flags
  import status_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pwr_up_i,
  input  logic       wdt_clr_i,
  input  logic       halt_i,
  input  logic       wdt_to_i,
  output sys_flags_t sys_o
);
  sys_flags_t sys_d;

  always_comb begin
    sys_d = sys_o;
    if (wdt_clr_i)           sys_d.pd = 1'b0;
    else if (halt_i)         sys_d.pd = 1'b1;
    if (wdt_to_i)            sys_d.to = 1'b1;
    else if (wdt_clr_i || halt_i) sys_d.to = 1'b0;
    if (pwr_up_i)            sys_d = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sys_o <= '0;
    else         sys_o <= sys_d;
  end

  a_r3_quiet_hold : assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pwr_up_i || wdt_clr_i || halt_i || wdt_to_i) |=> $stable(sys_o));
  a_r4_pd_halt : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt_i && !wdt_clr_i && !pwr_up_i) |=> sys_o.pd);
  a_r4_pd_clr : assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_clr_i |=> !sys_o.pd);
  a_r5_to_set : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wdt_to_i && !pwr_up_i) |=> sys_o.to);
  a_r5_to_clr : assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((wdt_clr_i || halt_i) && !wdt_to_i) |=> !sys_o.to);
  a_r6_pwr_up : assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_up_i |=> (sys_o == '0));
endmodule

// File: rtl/status_reg.sv
module status_reg
  import status_pkg::*;
#(
  parameter int unsigned          ADDR_W   = 8,
  parameter logic [ADDR_W-1:0]    REG_ADDR = 8'h0A
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [ADDR_W-1:0]        bus_addr_i,
  input  logic                     bus_we_i,
  input  logic [REG_W-1:0]         bus_wdata_i,
  output logic [REG_W-1:0]         bus_rdata_o,
  input  logic [NUM_ALU_FLAGS-1:0] alu_upd_i,
  input  logic [NUM_ALU_FLAGS-1:0] alu_flags_i,
  input  logic                     pwr_up_i,
  input  logic                     wdt_clr_i,
  input  logic                     halt_i,
  input  logic                     wdt_to_i,
  output logic [REG_W-1:0]         status_o
);
  localparam int unsigned PAD_W = REG_W - NUM_ALU_FLAGS - 2;

  logic                     sel;
  logic                     wr_hit;
  logic [NUM_ALU_FLAGS-1:0] alu_q;
  sys_flags_t               sys_q;

  assign sel    = (bus_addr_i == REG_ADDR);
  assign wr_hit = sel && bus_we_i;

  status_alu_flags u_alu_flags (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_hit_i    (wr_hit),
    .wr_data_i   (bus_wdata_i[NUM_ALU_FLAGS-1:0]),
    .alu_upd_i   (alu_upd_i),
    .alu_flags_i (alu_flags_i),
    .flags_o     (alu_q)
  );

  status_sys_flags u_sys_flags (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pwr_up_i  (pwr_up_i),
    .wdt_clr_i (wdt_clr_i),
    .halt_i    (halt_i),
    .wdt_to_i  (wdt_to_i),
    .sys_o     (sys_q)
  );

  assign status_o    = {{PAD_W{1'b0}}, sys_q.to, sys_q.pd, alu_q};
  assign bus_rdata_o = sel ? status_o : '0;

  // R1: unused upper bits
  always_comb a_r1_pad_zero : assert (status_o[REG_W-1:TO_BIT+1] == '0);
  // R3: write alone leaves system flags
  a_r3_wr_protect : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_hit && !(pwr_up_i || wdt_clr_i || halt_i || wdt_to_i))
      |=> $stable(status_o[TO_BIT:PD_BIT]));
  // R2: write to own address lands when ALU idle
  a_r2_wr_lands : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_hit && alu_upd_i == '0)
      |=> status_o[NUM_ALU_FLAGS-1:0] == $past(bus_wdata_i[NUM_ALU_FLAGS-1:0]));
endmodule

// File: tb/status_reg_bench.sv
`timescale 1ns/1ps
module status_reg_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] addr = '0, wdata = '0;
  logic       we = 1'b0;
  logic [3:0] upd = '0, aflg = '0;
  logic       pwr = 1'b0, clr = 1'b0, hlt = 1'b0, to = 1'b0;
  logic [7:0] rdata, status;
  int vec = 0, bad = 0;
  logic [3:0] m_alu;
  logic       m_pd, m_to;

  always #4 clk = ~clk;

  status_reg u_status_reg (
    .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_we_i(we),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .alu_upd_i(upd),
    .alu_flags_i(aflg), .pwr_up_i(pwr), .wdt_clr_i(clr), .halt_i(hlt),
    .wdt_to_i(to), .status_o(status));

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    vec++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] model_byte();
    return {2'b00, m_to, m_pd, m_alu};
  endfunction

  // one clocked cycle from a falling edge; inputs released afterwards
  task automatic step();
    @(negedge clk);
    we = 0; upd = '0; pwr = 0; clr = 0; hlt = 0; to = 0;
  endtask

  task automatic ev(logic p, logic c, logic h, logic t);
    pwr = p; clr = c; hlt = h; to = t;
    if (c) m_pd = 0; else if (h) m_pd = 1;
    if (t) m_to = 1; else if (c || h) m_to = 0;
    if (p) begin m_pd = 0; m_to = 0; end
    step();
  endtask

  task automatic t_reset();
    m_alu = '0; m_pd = 0; m_to = 0;
    chk("R8 reset", status, 8'h00);
    addr = 8'h0A; #1;
    chk("R9 read hit after reset", rdata, 8'h00);
  endtask

  task automatic t_write();
    addr = 8'h0A; we = 1; wdata = 8'hFF; m_alu = 4'hF; step();
    chk("R2 write FF low nibble", status, model_byte());
    chk("R1 R3 upper bits zero after FF", status & 8'hF0, 8'h00);
    addr = 8'h0B; we = 1; wdata = 8'h00; step();
    chk("R2 other address ignored", status, model_byte());
    #1 chk("R9 read miss zero", rdata, 8'h00);
    addr = 8'h0A; #1 chk("R9 read hit", rdata, model_byte());
  endtask

  task automatic t_alu();
    addr = 8'h0A; we = 1; wdata = 8'h05; upd = 4'b0011; aflg = 4'b1010;
    m_alu = 4'b0110; step();
    chk("R7 alu wins masked bits", status, model_byte());
    upd = 4'b1100; aflg = 4'b1000; m_alu = 4'b1010; step();
    chk("R7 alu mask no write", status, model_byte());
  endtask

  task automatic t_events();
    for (int k = 0; k < 16; k++) begin
      ev(1, 0, 0, 0);
      ev(0, 0, 1, 1);
      chk("R5 preset to+pd", status, model_byte());
      ev(k[3], k[2], k[1], k[0]);
      chk($sformatf("R4 R5 R6 event combo %0d", k), status, model_byte());
      ev(0, k[0], k[1], k[2]);
      chk($sformatf("R4 R5 second combo %0d", k), status, model_byte());
    end
  endtask

  task automatic t_rand_wr();
    ev(0, 0, 1, 1);
    for (int i = 0; i < 200; i++) begin
      addr  = ($urandom_range(3) == 0) ? 8'($urandom) : 8'h0A;
      wdata = 8'($urandom);
      we    = 1;
      if (addr == 8'h0A) m_alu = wdata[3:0];
      step();
      chk("R3 random write sys flags", status, model_byte());
      if (i == 100) begin ev(1, 0, 0, 0); chk("R6 pwr_up keeps alu", status, model_byte()); end
    end
  endtask

  initial begin
    #(8 * 200000);
    bad++; vec++;
    $display("FAIL watchdog: got hang expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_write();
    t_alu();
    t_events();
    t_rand_wr();
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule